// File: doc/BRIEF.md
# DDR Secure Region Filter

This block sits in front of a DRAM port as a memory firewall. For every transaction it receives an address and a secure/non-secure attribute. It decides whether the target location belongs to secure memory. A non-secure master that touches secure memory is refused, and the offending address is reported on a one-cycle error pulse. Secure masters are never refused.

The decision comes from a small register file that a 32-bit write port programs. The file holds eight address windows with 1 MiB granularity. Each window has an inclusive start and end, both counted in megabytes. A control word then sets:

- a secure enable for each window;
- a secure flag for all memory that lies in none of the windows;
- a global bypass that makes every address non-secure.

Each write carries its own bit mask in the upper half-word. Writes from non-secure masters are dropped.

A three-state machine produces the verdict one cycle after the request:

- `ST_IDLE`: no request was presented.
- `ST_PASS`: the request was allowed.
- `ST_BLOCK`: the request was denied.

From any state, the transitions are:

- `to_idle` when no request is valid;
- `to_pass` when a request is valid and either the master is secure or the target is non-secure;
- `to_block` when a non-secure master targets secure memory.

Top module: `ddr_secure_filter`

## Requirements
- R1: After reset every window start and end reads 0, and the control word reads 0x200 (bypass set, all enables and the outside flag clear).
- R2: Register index n (0..7) holds the start of window n, index n+8 holds its end, and index 16 holds the control word. Window bounds are 16 bits and the control word is 10 bits. The read data has zeros above those widths, and any other index reads 0. The read data follows `reg_idx` combinationally.
- R3: A write uses `reg_wdata[31:16]` as a per-bit enable for `reg_wdata[15:0]`. A register bit changes only where its mask bit is 1, and the change is visible from the next cycle.
- R4: A write with `reg_wsecure` low changes no register.
- R5: Window n matches an address when `chk_addr[35:20]` is at least its start and at most its end, with both bounds inclusive.
- R6: Control bit n (0..7) makes window n secure. An address is secure if any enabled window matches it, so overlapping windows resolve toward secure.
- R7: A window whose end is below its start matches no address.
- R8: Control bit 8 makes every address that matches none of the eight windows secure, whether or not those windows are enabled.
- R9: Control bit 9 (bypass) makes every address non-secure, whatever the other bits hold.
- R10: A request with `chk_secure` high is always allowed.
- R11: For a request in cycle k, `res_valid` is high in cycle k+1 and in no cycle without a request the cycle before. When a non-secure request targets secure memory, `res_allow` is low in cycle k+1, `err_pulse` is high for that single cycle, and `err_addr` carries the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsecure | input | 1 | Write comes from a secure master |
| reg_idx | input | 5 | Register index for both read and write |
| reg_wdata | input | 32 | Write mask in 31:16, write data in 15:0 |
| reg_rdata | output | 32 | Contents of register `reg_idx` |
| chk_valid | input | 1 | Transaction check request |
| chk_secure | input | 1 | Transaction comes from a secure master |
| chk_addr | input | 36 | Transaction byte address |
| res_valid | output | 1 | Verdict valid, one cycle after the request |
| res_allow | output | 1 | Transaction allowed |
| err_pulse | output | 1 | One-cycle pulse on a denied transaction |
| err_addr | output | 36 | Address of the most recent denied transaction |

## Verification
The embedded assertions check the following on every cycle:

- a secure request always gets an allow;
- bypass forces an allow;
- the verdict latency is exactly one cycle, and no verdict appears without a request;
- an error pulse always carries the previous request's address;
- non-secure or zero-mask writes leave the configuration stable.

Only the bench's scenarios can show that the match decision itself is right, because that depends on the programmed contents. This covers the inclusive bounds at window edges, empty reversed windows, overlap toward secure, the outside flag, and masked read-back.

// File: rtl/ddrsf_pkg.sv
package ddrsf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PASS  = 2'd1,
        ST_BLOCK = 2'd2
    } chk_state_e;

    // Apply a half-word write whose per-bit enables sit in the upper half.
    function automatic logic [15:0] masked_update(input logic [15:0] old_val,
                                                  input logic [31:0] wword);
        logic [15:0] msk;
        msk = wword[31:16];
        return (old_val & ~msk) | (wword[15:0] & msk);
    endfunction

endpackage

// File: rtl/ddrsf_regfile.sv
module ddrsf_regfile
    import ddrsf_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int BOUND_W = 16,
    parameter int IDX_W   = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_secure,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [31:0]                       wr_data,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [31:0]                       rd_data,
    output logic [NUM_WIN-1:0][BOUND_W-1:0]   win_start,
    output logic [NUM_WIN-1:0][BOUND_W-1:0]   win_end,
    output logic [NUM_WIN-1:0]                win_en,
    output logic                              outside_sec,
    output logic                              bypass
);
    localparam int CTRL_W = NUM_WIN + 2;
    localparam int OUT_BIT = NUM_WIN;
    localparam int BYP_BIT = NUM_WIN + 1;
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(2 * NUM_WIN);
    localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << BYP_BIT;

    logic [NUM_WIN-1:0][BOUND_W-1:0] start_q, end_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic wr_ok;

    assign wr_ok = wr_en && wr_secure;

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        logic [15:0] start_nx, end_nx;
        assign start_nx = masked_update(16'(start_q[i]), wr_data);
        assign end_nx   = masked_update(16'(end_q[i]), wr_data);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                start_q[i] <= '0;
                end_q[i]   <= '0;
            end else if (wr_ok) begin
                if (wr_idx == IDX_W'(i))
                    start_q[i] <= start_nx[BOUND_W-1:0];
                if (wr_idx == IDX_W'(i + NUM_WIN))
                    end_q[i] <= end_nx[BOUND_W-1:0];
            end
        end
    end

    logic [15:0] ctrl_nx;
    assign ctrl_nx = masked_update(16'(ctrl_q), wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else if (wr_ok && wr_idx == CTRL_IDX)
            ctrl_q <= ctrl_nx[CTRL_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (rd_idx == IDX_W'(i))
                rd_data[BOUND_W-1:0] = start_q[i];
            if (rd_idx == IDX_W'(i + NUM_WIN))
                rd_data[BOUND_W-1:0] = end_q[i];
        end
        if (rd_idx == CTRL_IDX)
            rd_data[CTRL_W-1:0] = ctrl_q;
    end

    assign win_start   = start_q;
    assign win_end     = end_q;
    assign win_en      = ctrl_q[NUM_WIN-1:0];
    assign outside_sec = ctrl_q[OUT_BIT];
    assign bypass      = ctrl_q[BYP_BIT];

    // R4: writes from a non-secure master leave the file untouched
    assert_ns_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_secure) |=> ($stable(start_q) && $stable(end_q) && $stable(ctrl_q)));

    // R3: a write with an all-zero mask changes nothing
    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[31:16] == 16'h0) |=> ($stable(start_q) && $stable(end_q) && $stable(ctrl_q)));

endmodule

// File: rtl/ddrsf_window_match.sv
module ddrsf_window_match #(
    parameter int NUM_WIN = 8,
    parameter int BOUND_W = 16
) (
    input  logic [BOUND_W-1:0]              addr_mb,
    input  logic [NUM_WIN-1:0][BOUND_W-1:0] win_start,
    input  logic [NUM_WIN-1:0][BOUND_W-1:0] win_end,
    input  logic [NUM_WIN-1:0]              win_en,
    input  logic                            outside_sec,
    input  logic                            bypass,
    output logic                            is_secure
);
    logic [NUM_WIN-1:0] hit;

    // A reversed window (end below start) cannot satisfy both bounds.
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
        assign hit[i] = (addr_mb >= win_start[i]) && (addr_mb <= win_end[i]);
    end

    logic in_secure_win, in_no_win;
    assign in_secure_win = |(hit & win_en);
    assign in_no_win     = ~(|hit);

    assign is_secure = !bypass && (in_secure_win || (outside_sec && in_no_win));

endmodule

// File: rtl/ddrsf_check_fsm.sv
module ddrsf_check_fsm
    import ddrsf_pkg::*;
#(
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chk_valid,
    input  logic              chk_secure,
    input  logic              target_secure,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              res_valid,
    output logic              res_allow,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] err_addr
);
    chk_state_e state_q, state_d;
    logic [ADDR_W-1:0] err_addr_q;

    always_comb begin
        if (!chk_valid)
            state_d = ST_IDLE;
        else if (!chk_secure && target_secure)
            state_d = ST_BLOCK;
        else
            state_d = ST_PASS;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_BLOCK)
                err_addr_q <= chk_addr;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_allow = 1'b0;
        err_pulse = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PASS: begin
                res_valid = 1'b1;
                res_allow = 1'b1;
            end
            ST_BLOCK: begin
                res_valid = 1'b1;
                err_pulse = 1'b1;
            end
            default: ;
        endcase
    end

    assign err_addr = err_addr_q;

    // R10: secure masters are never refused
    assert_secure_allowed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && chk_secure) |=> (res_valid && res_allow));

    // R11: a verdict follows every request one cycle later
    assert_verdict_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> res_valid);

    // R11: no verdict without a request
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !res_valid);

    // R11: the error pulse names the denied non-secure request's address
    assert_err_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> (!res_allow && $past(chk_valid) && !$past(chk_secure)
                       && err_addr == $past(chk_addr)));

endmodule

// File: rtl/ddr_secure_filter.sv
module ddr_secure_filter #(
    parameter int ADDR_W    = 36,
    parameter int NUM_WIN   = 8,
    parameter int GRAN_LOG2 = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_wsecure,
    input  logic [4:0]        reg_idx,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              chk_valid,
    input  logic              chk_secure,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              res_valid,
    output logic              res_allow,
    output logic              err_pulse,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int BOUND_W = ADDR_W - GRAN_LOG2;
    localparam int IDX_W   = 5;

    logic [NUM_WIN-1:0][BOUND_W-1:0] win_start, win_end;
    logic [NUM_WIN-1:0] win_en;
    logic outside_sec, bypass, target_secure;

    ddrsf_regfile #(
        .NUM_WIN(NUM_WIN), .BOUND_W(BOUND_W), .IDX_W(IDX_W)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_secure(reg_wsecure), .wr_idx(reg_idx),
        .wr_data(reg_wdata), .rd_idx(reg_idx), .rd_data(reg_rdata),
        .win_start(win_start), .win_end(win_end), .win_en(win_en),
        .outside_sec(outside_sec), .bypass(bypass)
    );

    ddrsf_window_match #(
        .NUM_WIN(NUM_WIN), .BOUND_W(BOUND_W)
    ) match_i (
        .addr_mb(chk_addr[ADDR_W-1:GRAN_LOG2]),
        .win_start(win_start), .win_end(win_end), .win_en(win_en),
        .outside_sec(outside_sec), .bypass(bypass),
        .is_secure(target_secure)
    );

    ddrsf_check_fsm #(
        .ADDR_W(ADDR_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n),
        .chk_valid(chk_valid), .chk_secure(chk_secure),
        .target_secure(target_secure), .chk_addr(chk_addr),
        .res_valid(res_valid), .res_allow(res_allow),
        .err_pulse(err_pulse), .err_addr(err_addr)
    );

    // R9: with bypass set nothing is refused
    assert_bypass_allows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_valid && bypass) |=> res_allow);

endmodule

// File: tb/ddr_secure_filter_tb.sv
module ddr_secure_filter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_wsecure = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        chk_valid = 1'b0, chk_secure = 1'b0;
    logic [35:0] chk_addr = '0;
    logic        res_valid, res_allow, err_pulse;
    logic [35:0] err_addr;

    always #10 clk = ~clk;

    ddr_secure_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_wsecure(reg_wsecure), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chk_valid(chk_valid), .chk_secure(chk_secure), .chk_addr(chk_addr),
        .res_valid(res_valid), .res_allow(res_allow),
        .err_pulse(err_pulse), .err_addr(err_addr)
    );

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int unsigned m_start[8];
    int unsigned m_end[8];
    int unsigned m_ctrl;
    bit          e_valid, e_allow, e_err;
    logic [35:0] e_addr;

    function automatic bit m_is_secure(logic [35:0] a);
        int unsigned mb = a[35:20];
        bit any = 0, sec = 0;
        if (m_ctrl[9]) return 0;
        foreach (m_start[i]) begin
            if (mb >= m_start[i] && mb <= m_end[i]) begin
                any = 1;
                if (m_ctrl[i]) sec = 1;
            end
        end
        if (!any && m_ctrl[8]) sec = 1;
        return sec;
    endfunction

    function automatic int unsigned m_apply(int unsigned old, logic [31:0] w, int unsigned keep);
        int unsigned msk = w[31:16];
        return ((old & ~msk) | (w[15:0] & msk)) & keep;
    endfunction

    function automatic int unsigned m_read(int idx);
        if (idx < 8) return m_start[idx];
        if (idx < 16) return m_end[idx-8];
        if (idx == 16) return m_ctrl;
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (m_start[i]) begin m_start[i] = 0; m_end[i] = 0; end
            m_ctrl = 32'h200;
            e_valid = 0; e_allow = 0; e_err = 0; e_addr = '0;
        end else begin
            bit sec;
            sec = m_is_secure(chk_addr);
            e_valid = chk_valid;
            e_allow = chk_valid && (chk_secure || !sec);
            e_err   = chk_valid && !chk_secure && sec;
            if (e_err) e_addr = chk_addr;
            if (reg_wr && reg_wsecure) begin
                if (reg_idx < 8) m_start[reg_idx] = m_apply(m_start[reg_idx], reg_wdata, 32'hFFFF);
                else if (reg_idx < 16) m_end[reg_idx-8] = m_apply(m_end[reg_idx-8], reg_wdata, 32'hFFFF);
                else if (reg_idx == 16) m_ctrl = m_apply(m_ctrl, reg_wdata, 32'h3FF);
            end
        end
    end

    // Cycle compare of the registered outputs
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (res_valid !== e_valid || res_allow !== e_allow || err_pulse !== e_err
                || (e_err && err_addr !== e_addr)) begin
                fails++;
                $display("FAIL %s: valid/allow/err/addr = %b/%b/%b/%h expected %b/%b/%b/%h",
                         cur_req, res_valid, res_allow, err_pulse, err_addr,
                         e_valid, e_allow, e_err, e_addr);
            end
        end
    end

    task automatic rd_check(input int idx, input string req);
        logic [31:0] exp;
        reg_idx = 5'(idx);
        #1;
        exp = m_read(idx);
        vectors++;
        if (reg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: reg %0d read %h expected %h", req, idx, reg_rdata, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] w, input bit sec);
        reg_wr = 1; reg_wsecure = sec; reg_idx = 5'(idx); reg_wdata = w;
        @(negedge clk);
        reg_wr = 0; reg_wsecure = 0;
    endtask

    task automatic chk(input logic [35:0] a, input bit sec);
        chk_valid = 1; chk_secure = sec; chk_addr = a;
        @(negedge clk);
        chk_valid = 0;
    endtask

    function automatic logic [35:0] mb(input int n, input int off);
        return {16'(n), 20'(off)};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 / R2: reset contents and map, including unmapped indices
        cur_req = "R1";
        rd_check(16, "R1");
        if (m_read(16) != 32'h200) $display("bench model reset mismatch");
        for (int i = 0; i < 16; i++) rd_check(i, "R1");
        cur_req = "R2";
        for (int i = 17; i < 32; i++) rd_check(i, "R2");

        // R5 / R6: window 0 covers [0, 32 MiB), bypass cleared
        cur_req = "R5";
        wr(0, 32'hFFFF_0000, 1);
        wr(8, 32'hFFFF_001F, 1);
        wr(16, 32'h03FF_0001, 1);
        rd_check(16, "R2");
        rd_check(8, "R2");
        chk(mb(0, 0), 0);
        chk(mb(31, 20'hFFFFF), 0);
        chk(mb(32, 0), 0);
        chk(36'hF_FFFF_FFFF, 0);
        @(negedge clk);
        cur_req = "R10";
        chk(mb(5, 123), 1);
        chk(mb(40, 0), 1);

        // R3: masked writes
        cur_req = "R3";
        wr(1, 32'h00FF_AB12, 1);
        rd_check(1, "R3");
        wr(1, 32'h0000_FFFF, 1);
        rd_check(1, "R3");
        wr(16, 32'h0100_FFFF, 1);
        rd_check(16, "R3");
        wr(16, 32'h0100_0000, 1);
        rd_check(16, "R3");

        // R4: non-secure writes are dropped
        cur_req = "R4";
        wr(16, 32'hFFFF_0200, 0);
        rd_check(16, "R4");
        wr(0, 32'hFFFF_0100, 0);
        rd_check(0, "R4");
        chk(mb(3, 0), 0);
        @(negedge clk);

        // R7: reversed window 2 is empty even when enabled
        cur_req = "R7";
        wr(2, 32'hFFFF_0064, 1);
        wr(10, 32'hFFFF_0032, 1);
        wr(16, 32'h0004_0004, 1);
        chk(mb(60, 0), 0);
        chk(mb(100, 0), 0);
        chk(mb(50, 0), 0);

        // R8: outside flag secures memory outside every window
        cur_req = "R8";
        wr(3, 32'hFFFF_00C8, 1);
        wr(11, 32'hFFFF_012C, 1);
        wr(16, 32'h0100_0100, 1);
        chk(mb(500, 7), 0);
        chk(mb(250, 0), 0);
        chk(mb(60, 0), 0);
        chk(mb(0, 9), 0);
        wr(16, 32'h0100_0000, 1);

        // R6: overlap resolves toward secure
        cur_req = "R6";
        wr(5, 32'hFFFF_00FA, 1);
        wr(13, 32'hFFFF_0104, 1);
        wr(16, 32'h0020_0020, 1);
        chk(mb(255, 0), 0);
        chk(mb(250, 0), 0);
        chk(mb(260, 20'hFFFFF), 0);
        chk(mb(261, 0), 0);
        chk(mb(270, 0), 0);

        // R11: back-to-back requests and error address capture
        cur_req = "R11";
        chk(mb(10, 16'h1234), 0);
        chk(mb(255, 16'h4321), 0);
        chk(mb(20, 0), 0);
        chk(mb(252, 16'hABC), 0);
        repeat (3) @(negedge clk);

        // R5: pseudo-random sweep under mixed config with outside flag on
        cur_req = "R5";
        wr(16, 32'h0100_0100, 1);
        begin
            logic [35:0] lfsr = 36'h9_1234_5678;
            for (int n = 0; n < 300; n++) begin
                lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
                chk({8'h0, lfsr[27:0]} ^ {lfsr[35:28], 28'h0} & 36'h00FF_FFFF_F, lfsr[3]);
                if (lfsr[5]) @(negedge clk);
            end
        end

        // R9: bypass overrides every secure setting
        cur_req = "R9";
        wr(16, 32'h0200_0200, 1);
        chk(mb(255, 0), 0);
        chk(mb(500, 0), 0);
        chk(mb(0, 0), 0);
        repeat (2) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule